// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block takes one stereo sample pair per frame and shifts it out on a three-wire serial audio link that it drives as clock master. A divider on the master clock produces the bit clock. The block counts 64 bit clocks per frame, 32 in each channel slot. It drives the frame clock and the data line from that count.

A 3-bit format field picks one of four framings: I2S, left-justified, right-justified and a DSP-style short-pulse format. A 2-bit width field sets the word length used in right-justified framing. The sample words, the format and the width are all captured when a frame opens, so a host may update them at any time without tearing the frame being sent. Data and frame clock change only on falling bit-clock edges, so a receiver samples on rising edges.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is asserted, and until the first falling bit-clock edge after it, bclk is 0, lrclk is 1 and sdata is 0.
- R2: bclk toggles every DIV_HALF master-clock cycles. A frame is 64 bit clocks, numbered 0 to 63: the left slot is 0..31 and the right slot is 32..63. The first falling bclk edge after reset opens bit clock 0.
- R3: sdata and lrclk change only in the master-clock cycle in which bclk falls.
- R4: fmt_sel encodes 000 = I2S, 001 = right-justified, 010 = DSP, 011 = left-justified. Any other value behaves as I2S.
- R5: In I2S, lrclk is 0 during the left slot and 1 during the right slot. The 24-bit word goes out MSB first at slot bit 1 through slot bit 24, and every other slot bit is 0.
- R6: In left-justified framing, lrclk is 1 during the left slot and 0 during the right slot. The word goes out MSB first at slot bits 0 to 23, and slot bits 24 to 31 are 0.
- R7: Right-justified framing uses the same lrclk as R6. rj_width encodes 00 = 24, 01 = 20, 10 = 18, 11 = 16 bits. The upper W bits of the sample are sent MSB first so that the last one lands on slot bit 31, and all earlier slot bits are 0.
- R8: In DSP framing, lrclk is 1 only during bit clock 0 of the frame. The left word occupies bit clocks 1 to 24 and the right word bit clocks 25 to 48, both MSB first. Bit clocks 0 and 49 to 63 are 0.
- R9: The samples, fmt_sel and rj_width are taken when a frame opens. A strobe or a control change during a frame has no effect on that frame and applies from the next one.
- R10: A strobe in the same master-clock cycle as the falling edge that opens a frame is used for that frame. When no new strobe arrives, the last sample pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: a new sample pair is on smp_left/smp_right |
| smp_left | input | SAMPLE_W | Left-channel sample |
| smp_right | input | SAMPLE_W | Right-channel sample |
| fmt_sel | input | 3 | Framing select (see R4) |
| rj_width | input | 2 | Right-justified word width select (see R7) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data |

## Verification
A new-sample strobe can fall in the same master-clock cycle as the falling bit-clock edge that opens a frame, so the strobe and the frame-start capture happen together. The bench counts rising bit-clock edges from reset to find bit clock 63. It then waits exactly DIV_HALF master-clock cycles and raises the strobe for the cycle in which bclk falls. The format is left-justified, so bit clock 0 already carries the new MSB. The whole captured frame must match the new pair with no bit of the old one, and a strobe raised mid-frame must leave the frame it lands in untouched.

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
  parameter int DIV_HALF = 2,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          rj_width,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int IW = $clog2(SAMPLE_W);

  logic [DW-1:0]       dcnt;
  logic [5:0]          pos;
  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, e_l, e_r;
  logic [2:0]          cur_mode, e_mode;
  logic [1:0]          cur_w, e_w;
  logic                nb, nlr;

  wire       tick     = (dcnt == DW'(DIV_HALF - 1));
  wire       fall_ev  = tick & bclk;
  wire       frame_go = fall_ev && (pos == 6'd63);
  wire [5:0] np       = pos + 6'd1;

  assign e_l    = frame_go ? (smp_vld ? smp_left  : pend_l) : cur_l;
  assign e_r    = frame_go ? (smp_vld ? smp_right : pend_r) : cur_r;
  assign e_mode = frame_go ? fmt_sel  : cur_mode;
  assign e_w    = frame_go ? rj_width : cur_w;

  always_comb begin
    int idx, k, wd;
    logic [SAMPLE_W-1:0] word;
    idx  = int'(np[4:0]);
    k    = 0;
    word = np[5] ? e_r : e_l;
    case (e_w)
      2'd0:    wd = 24;
      2'd1:    wd = 20;
      2'd2:    wd = 18;
      default: wd = 16;
    endcase
    nb  = 1'b0;
    nlr = np[5];
    case (e_mode)
      3'd1: begin
        nlr = ~np[5];
        if (idx >= 32 - wd) begin
          k  = SAMPLE_W - 1 - (idx - (32 - wd));
          nb = word[IW'(k)];
        end
      end
      3'd2: begin
        nlr = (np == 6'd0);
        k   = int'(np);
        if (k >= 1 && k <= SAMPLE_W)
          nb = e_l[IW'(SAMPLE_W - k)];
        else if (k > SAMPLE_W && k <= 2 * SAMPLE_W)
          nb = e_r[IW'(2 * SAMPLE_W - k)];
      end
      3'd3: begin
        nlr = ~np[5];
        if (idx < SAMPLE_W) nb = word[IW'(SAMPLE_W - 1 - idx)];
      end
      default: begin
        if (idx >= 1 && idx <= SAMPLE_W) nb = word[IW'(SAMPLE_W - idx)];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt     <= '0;
      bclk     <= 1'b0;
      pos      <= 6'd63;
      lrclk    <= 1'b1;
      sdata    <= 1'b0;
      pend_l   <= '0;
      pend_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      cur_mode <= 3'd0;
      cur_w    <= 2'd0;
    end else begin
      dcnt <= tick ? '0 : dcnt + DW'(1);
      if (tick) bclk <= ~bclk;
      if (fall_ev) begin
        pos   <= np;
        sdata <= nb;
        lrclk <= nlr;
      end
      if (smp_vld) begin
        pend_l <= smp_left;
        pend_r <= smp_right;
      end
      if (frame_go) begin
        cur_l    <= e_l;
        cur_r    <= e_r;
        cur_mode <= e_mode;
        cur_w    <= e_w;
      end
    end
  end
endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk #(
  parameter int DIV_HALF = 2,
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bclk,
  input logic                lrclk,
  input logic                sdata,
  input logic [5:0]          pos,
  input logic [2:0]          cur_mode,
  input logic [1:0]          cur_w,
  input logic [SAMPLE_W-1:0] cur_l
);
  logic [5:0] rj_lead;
  always_comb begin
    case (cur_w)
      2'd0:    rj_lead = 6'd8;
      2'd1:    rj_lead = 6'd12;
      2'd2:    rj_lead = 6'd14;
      default: rj_lead = 6'd16;
    endcase
  end

  // R3
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk) |-> ($stable(sdata) && $stable(lrclk)));

  // R2
  bclk_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_HALF > 1 && !$stable(bclk)) |=> $stable(bclk));

  // R7
  rj_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'd1 && {1'b0, pos[4:0]} < rj_lead) |-> !sdata);

  // R5
  i2s_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'd0 || cur_mode > 3'd3) |-> (lrclk == pos[5]));

  // R8
  dsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'd2) |-> (lrclk == (pos == 6'd0)));

  // R9
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_l) |-> (pos == 6'd0));
endmodule

bind aud_serial_tx aud_serial_tx_chk #(.DIV_HALF(DIV_HALF), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
  .pos(pos), .cur_mode(cur_mode), .cur_w(cur_w), .cur_l(cur_l)
);

// File: tb/aud_serial_tx_test.sv
`timescale 1ns/1ps
module aud_serial_tx_test;
  localparam int DIVH = 2;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic [2:0] fmt_sel = 3'd0;
  logic [1:0] rj_width = 2'd0;
  logic bclk, lrclk, sdata;

  int checks = 0, errors = 0, rcount = 0;
  logic [63:0] cap_d, cap_lr;

  bit mid_en = 0, coin_en = 0;
  logic [23:0] mid_l, mid_r, coin_l, coin_r;
  logic [2:0] mid_mode;
  logic [1:0] mid_w;

  aud_serial_tx #(.DIV_HALF(DIVH), .SAMPLE_W(24)) uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_left(smp_left),
    .smp_right(smp_right), .fmt_sel(fmt_sel), .rj_width(rj_width),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata));

  always #4 clk = ~clk;
  always @(posedge bclk) rcount++;

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_data(input logic [2:0] m, input logic [1:0] w,
                                           input logic [23:0] l, input logic [23:0] r);
    logic [63:0] f = '0;
    int n;
    n = (w == 0) ? 24 : (w == 1) ? 20 : (w == 2) ? 18 : 16;
    for (int b = 0; b < 24; b++) begin
      case (m)
        3'd3: begin f[b] = l[23-b]; f[32+b] = r[23-b]; end
        3'd2: begin f[1+b] = l[23-b]; f[25+b] = r[23-b]; end
        3'd1: if (b < n) begin f[31-b] = l[24-n+b]; f[63-b] = r[24-n+b]; end
        default: begin f[1+b] = l[23-b]; f[33+b] = r[23-b]; end
      endcase
    end
    return f;
  endfunction

  function automatic logic [63:0] exp_lr(input logic [2:0] m);
    case (m)
      3'd1, 3'd3: return {32'h0, 32'hFFFF_FFFF};
      3'd2:       return 64'h1;
      default:    return {32'hFFFF_FFFF, 32'h0};
    endcase
  endfunction

  task automatic strobe(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    smp_left = l; smp_right = r; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic wait_pos(input int p);
    do begin
      @(posedge bclk); #1;
    end while (((rcount + 62) % 64) != p);
  endtask

  task automatic capture();
    wait_pos(63);
    if (coin_en) begin
      for (int i = 0; i < DIVH; i++) @(negedge clk);
      smp_left = coin_l; smp_right = coin_r; smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
    end
    for (int p = 0; p < 64; p++) begin
      @(posedge bclk); #1;
      cap_d[p]  = sdata;
      cap_lr[p] = lrclk;
      if (mid_en && p == 10) begin
        fmt_sel = mid_mode; rj_width = mid_w;
        strobe(mid_l, mid_r);
      end
    end
  endtask

  task automatic run_frame(input string req, input logic [2:0] m, input logic [1:0] w,
                           input logic [23:0] l, input logic [23:0] r);
    fmt_sel = m; rj_width = w;
    strobe(l, r);
    capture();
    chk({req, " data"}, cap_d, exp_data(m, w, l, r));
    chk({req, " lrclk"}, cap_lr, exp_lr(m));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 reset", {61'h0, bclk, lrclk, sdata}, 64'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {61'h0, bclk, lrclk, sdata}, 64'b010);
  endtask

  task automatic t_period();
    realtime t0, t1;
    @(posedge bclk); t0 = $realtime;
    @(posedge bclk); t1 = $realtime;
    chk("R2 bclk period", 64'(int'(t1 - t0)), 64'(2 * DIVH * 8));
  endtask

  task automatic t_formats();
    run_frame("R5 I2S", 3'd0, 2'd0, 24'hA5C3F1, 24'h3C9E57);
    run_frame("R6 LJ", 3'd3, 2'd0, 24'h8F0E1D, 24'h71B2C4);
    for (int w = 0; w < 4; w++)
      run_frame("R7 RJ", 3'd1, 2'(w), 24'hD3A7F5, 24'hB6E9C1);
    run_frame("R8 DSP", 3'd2, 2'd0, 24'hC0FFEE, 24'h9ABCDE);
    run_frame("R4 fallback", 3'd6, 2'd1, 24'h5A5A5A, 24'hE1E2E3);
  endtask

  task automatic t_midframe();
    fmt_sel = 3'd3; rj_width = 2'd0;
    strobe(24'h123456, 24'h89ABCD);
    mid_en = 1; mid_l = 24'hFEDCBA; mid_r = 24'h0F1E2D; mid_mode = 3'd1; mid_w = 2'd3;
    capture();
    mid_en = 0;
    chk("R9 mid-frame data ignored", cap_d, exp_data(3'd3, 2'd0, 24'h123456, 24'h89ABCD));
    chk("R9 mid-frame mode ignored", cap_lr, exp_lr(3'd3));
    capture();
    chk("R9 next frame new", cap_d, exp_data(3'd1, 2'd3, 24'hFEDCBA, 24'h0F1E2D));
  endtask

  task automatic t_coincident();
    fmt_sel = 3'd3; rj_width = 2'd0;
    strobe(24'h111111, 24'h222222);
    coin_en = 1; coin_l = 24'hE7C3A1; coin_r = 24'h96B4D2;
    capture();
    coin_en = 0;
    chk("R10 coincident strobe", cap_d, exp_data(3'd3, 2'd0, 24'hE7C3A1, 24'h96B4D2));
    capture();
    chk("R10 repeat last pair", cap_d, exp_data(3'd3, 2'd0, 24'hE7C3A1, 24'h96B4D2));
  endtask

  initial begin
    t_reset();
    t_period();
    t_formats();
    t_midframe();
    t_coincident();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule